// File: doc/BRIEF.md
# Triggered Audio Word Counter

This block counts word-select transitions on a serial audio link so that the true sample rate can be measured against a periodic reference. Each word-select edge arrives as a one-cycle strobe, `ws_edge`, and adds one to a 10-bit running count. When a capture happens, the running count is copied into a capture register and cleared in the same clock cycle, so no edge is lost or counted twice. A capture can come from a software write strobe or from one of three hardware events: a 1 ms frame-start pulse, a timer channel-0 compare pulse, or an input-pin transition pulse.

A 2-bit select field chooses which hardware event, if any, may cause a capture. The running count stops at 1023 instead of wrapping. Software reads the captured value as a 2-bit upper field and an 8-bit lower field.

The count is kept by a two-state machine. `CNT_RUN` is the state in which edges increment the count. `CNT_FULL` is the state in which the count is held at 1023. The transitions are:

- `CNT_RUN` → `CNT_FULL`, named *reach_max*, when an edge brings the count to 1023 with no capture in that cycle.
- `CNT_FULL` → `CNT_RUN`, named *restart*, on any capture.
- `CNT_RUN` → `CNT_RUN`, named *count_or_clear*, on every other cycle in `CNT_RUN`.
- `CNT_FULL` → `CNT_FULL`, named *hold_max*, when there is no capture.

Top module: `ws_word_counter`

## Requirements
- R1: After reset, the captured value `{cap_hi, cap_lo}` is 0 and the running count is 0.
- R2: Each cycle with `ws_edge` high and no capture adds exactly one to the running count, while the count is below 1023.
- R3: A capture copies the running count into the capture register and clears the running count to 0. The new captured value appears on the outputs one clock after the capture cycle. A software capture is caused by `sw_load` high.
- R4: With `trig_sel` = 0, the `evt_frame`, `evt_timer` and `evt_pin` inputs cause no capture. Only `sw_load` captures.
- R5: Each `trig_sel` value enables exactly one event input, and the other two event inputs are ignored:
    - `trig_sel` = 1 enables `evt_frame`.
    - `trig_sel` = 2 enables `evt_timer`.
    - `trig_sel` = 3 enables `evt_pin`.
- R6: The running count saturates at 1023. Further edges leave it at 1023 until the next capture.
- R7: When `ws_edge` and a capture occur in the same cycle, the captured value includes that edge, and the running count restarts at 0.
- R8: The captured value holds unchanged in every cycle without a capture.
- R9: `cap_hi` carries bits 9:8 of the captured value, and `cap_lo` carries bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ws_edge | input | 1 | One-cycle strobe for each word-select transition |
| evt_frame | input | 1 | Frame-start event strobe (source 1) |
| evt_timer | input | 1 | Timer compare event strobe (source 2) |
| evt_pin | input | 1 | Pin transition event strobe (source 3) |
| trig_sel | input | 2 | Hardware trigger select; 0 disables hardware triggers |
| sw_load | input | 1 | Software write strobe: capture and clear |
| cap_hi | output | 2 | Captured count, bits 9:8 |
| cap_lo | output | 8 | Captured count, bits 7:0 |

## Verification
The running count is internal, so a wrong count or a wrong state stays hidden until the next capture. It then appears on `cap_hi`/`cap_lo` one clock after the capture cycle. The bench therefore follows every burst of edges with a capture, and compares the outputs with a behavioural model on every clock.

Three faults show up as a captured value that is off by one or more:
- a lost or doubled edge;
- a missed clear;
- a wrong choice between the `CNT_RUN` and `CNT_FULL` states.

Two further faults show up differently:
- A wrong trigger mapping gives a capture in the wrong cycle, or no capture at all.
- A wrap instead of saturation shows as a small value where 1023 is expected.

// File: rtl/wcnt_pkg.sv
package wcnt_pkg;
    typedef enum logic [0:0] {
        CNT_RUN  = 1'b0,
        CNT_FULL = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/wcnt_trig_select.sv
module wcnt_trig_select #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] evt,
    input  logic [SEL_W-1:0] sel,
    input  logic             sw_load,
    output logic             fire
);
    logic [N_SRC-1:0] hit;

    // Source i is enabled by select value i+1; select value 0 enables none.
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            assign hit[i] = evt[i] && (sel == SEL_W'(i + 1));
        end
    endgenerate

    assign fire = sw_load || (|hit);
endmodule

// File: rtl/wcnt_sat_counter.sv
module wcnt_sat_counter
    import wcnt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ws_edge,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic [W-1:0] next_val
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    cnt_state_e state, state_nx;
    logic [W-1:0] count_nx;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CNT_RUN;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    // Next state and count.
    always_comb begin
        next_val = count;
        state_nx = state;
        unique case (state)
            CNT_RUN: begin
                if (ws_edge) next_val = count + 1'b1;
                state_nx = (next_val == MAX) ? CNT_FULL : CNT_RUN;
            end
            CNT_FULL: begin
                next_val = MAX;
                state_nx = CNT_FULL;
            end
            default: begin
                next_val = count;
                state_nx = CNT_RUN;
            end
        endcase
        if (clear) begin
            state_nx = CNT_RUN;
            count_nx = '0;
        end else begin
            count_nx = next_val;
        end
    end

    assert_saturate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_FULL && !clear) |=> (count == MAX));
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && ws_edge && count != MAX) |=> (count == $past(count) + 1'b1));
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
endmodule

// File: rtl/wcnt_capture_reg.sv
module wcnt_capture_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    assert_hold_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
    assert_take_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dout == $past(din)));
endmodule

// File: rtl/ws_word_counter.sv
module ws_word_counter #(
    parameter int CNT_W = 10,
    parameter int LO_W  = 8,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ws_edge,
    input  logic                   evt_frame,
    input  logic                   evt_timer,
    input  logic                   evt_pin,
    input  logic [SEL_W-1:0]       trig_sel,
    input  logic                   sw_load,
    output logic [CNT_W-LO_W-1:0]  cap_hi,
    output logic [LO_W-1:0]        cap_lo
);
    localparam int N_SRC = 3;

    logic             fire;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] next_val;
    logic [CNT_W-1:0] cap_q;

    wcnt_trig_select #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
        .evt     ({evt_pin, evt_timer, evt_frame}),
        .sel     (trig_sel),
        .sw_load (sw_load),
        .fire    (fire)
    );

    wcnt_sat_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ws_edge  (ws_edge),
        .clear    (fire),
        .count    (count),
        .next_val (next_val)
    );

    wcnt_capture_reg #(.W(CNT_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fire),
        .din   (next_val),
        .dout  (cap_q)
    );

    assign cap_hi = cap_q[CNT_W-1:LO_W];
    assign cap_lo = cap_q[LO_W-1:0];

    assert_hw_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel == '0 && !sw_load && (evt_frame || evt_timer || evt_pin))
            |=> $stable({cap_hi, cap_lo}));
    assert_edge_in_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ws_edge && count != {CNT_W{1'b1}})
            |=> ({cap_hi, cap_lo} == $past(count) + 1'b1));
endmodule

// File: tb/ws_word_counter_test.sv
module ws_word_counter_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ws_edge = 1'b0;
    logic       evt_frame = 1'b0;
    logic       evt_timer = 1'b0;
    logic       evt_pin = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       sw_load = 1'b0;
    logic [1:0] cap_hi;
    logic [7:0] cap_lo;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_cap = 0;
    int cycles = 0;
    bit done = 0;

    ws_word_counter uut (
        .clk(clk), .rst_n(rst_n), .ws_edge(ws_edge), .evt_frame(evt_frame),
        .evt_timer(evt_timer), .evt_pin(evt_pin), .trig_sel(trig_sel),
        .sw_load(sw_load), .cap_hi(cap_hi), .cap_lo(cap_lo)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int exp);
        int act;
        act = {cap_hi, cap_lo};
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: captured=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the coming posedge, compare after it.
    task automatic step(input string req, input bit ws, input bit f, input bit t,
                        input bit p, input int sel, input bit sw);
        bit hw;
        bit cap_now;
        int after_edge;
        @(negedge clk);
        ws_edge = ws; evt_frame = f; evt_timer = t; evt_pin = p;
        trig_sel = 2'(sel); sw_load = sw;
        case (sel)
            1: hw = f;
            2: hw = t;
            3: hw = p;
            default: hw = 0;
        endcase
        cap_now = sw || hw;
        after_edge = (ws && m_cnt < 1023) ? m_cnt + 1 : m_cnt;
        if (cap_now) begin
            m_cap = after_edge;
            m_cnt = 0;
        end else begin
            m_cnt = after_edge;
        end
        @(posedge clk);
        #(PERIOD/4);
        check(req, m_cap);
        ws_edge = 0; evt_frame = 0; evt_timer = 0; evt_pin = 0; sw_load = 0;
    endtask

    task automatic edges(input string req, input int n, input int sel);
        for (int i = 0; i < n; i++) step(req, 1, 0, 0, 0, sel, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        #(PERIOD*3);
        check("R1 reset capture", 0);
        rst_n = 1'b1;
        step("R1 idle", 0, 0, 0, 0, 0, 0);
        step("R1 zero count captured", 0, 0, 0, 0, 0, 1);

        // R2/R3: count edges, software capture, verify clear.
        edges("R2 counting", 5, 0);
        step("R3 sw capture of 5", 0, 0, 0, 0, 0, 1);
        step("R3 cleared count captured", 0, 0, 0, 0, 0, 1);

        // R4: hardware events ignored with select 0.
        edges("R2 counting", 7, 0);
        step("R4 frame ignored", 0, 1, 0, 0, 0, 0);
        step("R4 timer ignored", 0, 0, 1, 0, 0, 0);
        step("R4 pin ignored", 0, 1, 1, 1, 0, 0);
        step("R4 count kept, sw capture", 0, 0, 0, 0, 0, 1);

        // R5: per-select mapping, non-selected sources ignored.
        for (int s = 1; s <= 3; s++) begin
            edges("R2 counting", 3 + s, s);
            step("R5 other sources ignored", 0, s != 1, s != 2, s != 3, s, 0);
            step("R5 selected source captures", 0, s == 1, s == 2, s == 3, s, 0);
            step("R5 count cleared", 1, 0, 0, 0, s, 0);
            step("R5 recapture", 0, s == 1, s == 2, s == 3, s, 0);
        end

        // R6: saturation at 1023.
        edges("R6 approach max", 1022, 0);
        step("R6 at max minus one", 0, 0, 0, 0, 0, 1);
        edges("R6 counting", 1100, 0);
        step("R6 saturated capture", 0, 0, 0, 0, 0, 1);
        edges("R6 to max", 1023, 0);
        step("R6 edge at max", 1, 0, 0, 0, 0, 0);
        step("R6 exact max", 0, 0, 0, 0, 0, 1);
        edges("R6 saturated", 1030, 1);
        step("R6 saturated with edge and trigger", 1, 1, 0, 0, 1, 0);
        step("R6 restart after saturation", 0, 0, 0, 0, 0, 1);

        // R7: edge and capture in the same cycle.
        edges("R2 counting", 3, 0);
        step("R7 edge included", 1, 0, 0, 0, 0, 1);
        step("R7 restart at zero", 0, 0, 0, 0, 0, 1);
        step("R7 edge with hw capture", 1, 0, 0, 1, 3, 0);

        // R8/R9: hold without capture; split fields.
        edges("R8 hold", 300, 2);
        step("R9 split fields", 0, 0, 1, 0, 2, 0);
        edges("R8 hold after capture", 20, 2);
        step("R8 hold no trigger", 0, 1, 0, 1, 2, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule